// File: doc/BRIEF.md
# Interrupt Status and Clear-on-Read Bank

This block gathers the twelve event sources of a two-wire serial bus controller and makes them visible to a host over a simple register bus. Ten of the sources are one-cycle event pulses that are captured in sticky status bits. The other two, receive full and transmit empty, are level conditions that track the FIFO state. A host-writable enable mask gates the sticky and level bits into a masked view. The single level interrupt output is asserted whenever any masked bit is set.

Every sticky bit has a dedicated register that clears only that bit when the host reads it. One shared register clears all sticky bits when read. Each transmit abort event also ORs a cause vector into an abort-cause register. That register keeps its contents until the abort status is cleared, so the host can read the cause before it acknowledges the abort. Event generation lies outside the block: the sources arrive on `src_in`.

Top module: `irq_event_bank`

## Requirements
- R1: After reset the sticky bits, the mask and the abort-cause register are all zero, and `irq_o` is low.
- R2: The status bits are encoded as follows. Sticky bits: 0x001 receive underflow, 0x002 receive overflow, 0x008 transmit overflow, 0x020 read request, 0x040 transmit abort, 0x080 receive done, 0x100 activity, 0x200 stop seen, 0x400 start seen, 0x800 general call. Level bits: 0x004 receive full, 0x010 transmit empty. A pulse on `src_in` at a sticky position sets that bit. The bit is visible in the raw status read at 0x34 from the cycle after the pulse.
- R3: The raw bits 0x004 and 0x010 follow `src_in` with one cycle of latency, and no clear read changes them.
- R4: A bus write to 0x30 loads `host_wdata` into the mask, and a read of 0x30 returns the mask. A read of 0x2c returns the raw status ANDed with the mask.
- R5: `irq_o` is the OR of all masked status bits, evaluated from registered state. It is low whenever the mask is zero.
- R6: The per-source clear registers lie at 0x44, 0x48, 0x4c, 0x50, 0x54, 0x58, 0x5c, 0x60, 0x64 and 0x68, assigned in turn to status bits 0, 1, 3, 5, 6, 7, 8, 9, 10 and 11. Reading one of them returns the bit's prior value in data bit 0 and clears only that bit.
- R7: A read of 0x40 clears every sticky bit and the abort-cause register. Data bit 0 returns 1 if any sticky bit was set.
- R8: While a transmit abort pulse is present, `abort_cause_in` is ORed into the abort-cause register. The register is read at 0x80, and its cause bits are: 0 seven-bit address not acknowledged, 1 first ten-bit address byte not acknowledged, 2 second ten-bit address byte not acknowledged, 3 data not acknowledged, 4 general call not acknowledged, 5 read after general call, 7 start byte acknowledged, 9 start byte with restart off, 10 ten-bit read with restart off, 11 controller disabled, 12 arbitration lost.
- R9: Reading the transmit-abort clear register at 0x54 also clears the abort-cause register.
- R10: If a source pulse arrives in the same cycle as a clear read of its bit, the bit stays set. For the abort bit, the cause register then holds only the newly arriving causes.
- R11: Read data is registered. `host_rvalid` and `host_rdata` are valid in the cycle after a read request. Unmapped addresses read as zero. A write to any address other than 0x30 changes no state, and a write to a clear address clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 12 | Event pulses (sticky positions) and FIFO levels (bits 2 and 4) |
| abort_cause_in | input | CAUSE_W (13) | Cause vector that accompanies a transmit abort pulse |
| host_req | input | 1 | Bus access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W (8) | Byte address of the register |
| host_wdata | input | 12 | Mask value for a write to 0x30 |
| host_rdata | output | DATA_W (32) | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after a read request |
| irq_o | output | 1 | Level interrupt, OR of the masked status |

## Verification
Every sticky, level, mask and cause update takes effect on the clock edge that samples the stimulus. The bench therefore drives inputs on the falling edge and checks `irq_o` and state reads at the next falling edge. Read data is due exactly one cycle after the request. The driver pushes each expected word into a queue when it issues the read, and a monitor pops and compares it on the falling edge where `host_rvalid` is high. A read issued right after a pulse or a clear therefore sees the updated state. The same-cycle race between an event and its clear read is driven on a single edge.

// File: rtl/irqb_pkg.sv
package irqb_pkg;

  localparam int NSRC = 12;

  // bit positions of the sources
  localparam int B_RX_UNDER = 0;
  localparam int B_RX_OVER  = 1;
  localparam int B_RX_FULL  = 2;
  localparam int B_TX_OVER  = 3;
  localparam int B_TX_EMPTY = 4;
  localparam int B_RD_REQ   = 5;
  localparam int B_TX_ABORT = 6;
  localparam int B_RX_DONE  = 7;
  localparam int B_ACTIVITY = 8;
  localparam int B_STOP     = 9;
  localparam int B_START    = 10;
  localparam int B_GCALL    = 11;

  // sources that follow a level instead of being latched
  localparam logic [NSRC-1:0] LVL_SRC = (NSRC'(1) << B_RX_FULL) | (NSRC'(1) << B_TX_EMPTY);

  // register map
  localparam int A_MSTAT   = 'h2c;
  localparam int A_MASK    = 'h30;
  localparam int A_RAW     = 'h34;
  localparam int A_CLR_ALL = 'h40;
  localparam int A_CLR_1ST = 'h44;
  localparam int A_CAUSE   = 'h80;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_MSTAT,
    RS_MASK,
    RS_RAW,
    RS_CLRALL,
    RS_CLR1,
    RS_CAUSE
  } rd_sel_e;

  // clear register of a latched source: one word per latched bit below it
  function automatic int clr_addr(input int b);
    int k;
    k = 0;
    for (int j = 0; j < b; j++) begin
      if (!LVL_SRC[j]) k++;
    end
    return A_CLR_1ST + 4 * k;
  endfunction

endpackage

// File: rtl/irqb_addr_dec.sv
module irqb_addr_dec import irqb_pkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output rd_sel_e           rd_sel,
  output logic [NSRC-1:0]   clr_one,
  output logic              clr_all,
  output logic              mask_we
);

  logic            rd;
  logic [NSRC-1:0] hit;

  assign rd = req & ~we;

  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    if (LVL_SRC[i]) begin : g_none
      assign hit[i] = 1'b0;
    end else begin : g_cmp
      assign hit[i] = (addr == ADDR_W'(clr_addr(i)));
    end
  end

  assign clr_one = hit & {NSRC{rd}};

  always_comb begin
    rd_sel  = RS_NONE;
    clr_all = 1'b0;
    mask_we = req & we & (addr == ADDR_W'(A_MASK));
    if (rd) begin
      if (|hit)                               rd_sel = RS_CLR1;
      else if (addr == ADDR_W'(A_MSTAT))      rd_sel = RS_MSTAT;
      else if (addr == ADDR_W'(A_MASK))       rd_sel = RS_MASK;
      else if (addr == ADDR_W'(A_RAW))        rd_sel = RS_RAW;
      else if (addr == ADDR_W'(A_CAUSE))      rd_sel = RS_CAUSE;
      else if (addr == ADDR_W'(A_CLR_ALL)) begin
        rd_sel  = RS_CLRALL;
        clr_all = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irqb_latch_cell.sv
module irqb_latch_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic raw
);

  logic q, d;

  // event has priority over a clear in the same cycle
  always_comb d = evt | (q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= d;
  end

  assign raw = q;

  // R10
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n) evt |=> raw);
  // R6
  clr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n) (clr && !evt) |=> !raw);

endmodule

// File: rtl/irqb_level_cell.sv
module irqb_level_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic raw
);

  logic q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= lvl;
  end

  assign raw = q;

  // R3
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> (raw == $past(lvl)));

endmodule

// File: rtl/irqb_cause_reg.sv
module irqb_cause_reg #(
  parameter int CAUSE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               abort_evt,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic               clr,
  output logic [CAUSE_W-1:0] cause
);

  logic [CAUSE_W-1:0] q, d;
  logic               en;

  assign en = abort_evt | clr;

  always_comb begin
    d = q;
    if (abort_evt) d = clr ? cause_in : (q | cause_in);
    else if (clr)  d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end

  assign cause = q;

  // R9
  cause_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !abort_evt) |=> (cause == '0));
  // R8
  cause_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> ((cause & $past(cause_in)) == $past(cause_in)));

endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank import irqb_pkg::*; #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NSRC-1:0]    src_in,
  input  logic [CAUSE_W-1:0] abort_cause_in,
  input  logic               host_req,
  input  logic               host_we,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [NSRC-1:0]    host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               host_rvalid,
  output logic               irq_o
);

  rd_sel_e            rd_sel;
  logic [NSRC-1:0]    clr_one;
  logic               clr_all;
  logic               mask_we;
  logic [NSRC-1:0]    raw;
  logic [NSRC-1:0]    mask_q;
  logic [CAUSE_W-1:0] cause;
  logic [DATA_W-1:0]  rdata_d, rdata_q;
  logic               rvalid_d, rvalid_q;
  logic [NSRC-1:0]    masked;

  irqb_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .req     (host_req),
    .we      (host_we),
    .addr    (host_addr),
    .rd_sel  (rd_sel),
    .clr_one (clr_one),
    .clr_all (clr_all),
    .mask_we (mask_we)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    if (LVL_SRC[i]) begin : g_lvl
      irqb_level_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (src_in[i]),
        .raw   (raw[i])
      );
    end else begin : g_lat
      irqb_latch_cell u_cell (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (src_in[i]),
        .clr   (clr_one[i] | clr_all),
        .raw   (raw[i])
      );
    end
  end

  irqb_cause_reg #(.CAUSE_W(CAUSE_W)) u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .abort_evt (src_in[B_TX_ABORT]),
    .cause_in  (abort_cause_in),
    .clr       (clr_one[B_TX_ABORT] | clr_all),
    .cause     (cause)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= host_wdata;
  end

  assign masked = raw & mask_q;

  always_comb begin
    rvalid_d = host_req & ~host_we;
    rdata_d  = '0;
    case (rd_sel)
      RS_MSTAT:  rdata_d = DATA_W'(masked);
      RS_MASK:   rdata_d = DATA_W'(mask_q);
      RS_RAW:    rdata_d = DATA_W'(raw);
      RS_CLRALL: rdata_d = DATA_W'(|(raw & ~LVL_SRC));
      RS_CLR1:   rdata_d = DATA_W'(|(raw & clr_one));
      RS_CAUSE:  rdata_d = DATA_W'(cause);
      default:   rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_d;
      rvalid_q <= rvalid_d;
    end
  end

  assign host_rdata  = rdata_q;
  assign host_rvalid = rvalid_q;
  assign irq_o       = |masked;

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_addr == ADDR_W'(A_MASK)) |=> (mask_q == $past(host_wdata)));
  // R11
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we) |=> host_rvalid);
  // R11
  no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rvalid);
  // R5
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

endmodule

// File: tb/tb_irq_event_bank.sv
module tb_irq_event_bank;

  logic        clk, rst_n;
  logic [11:0] src_in;
  logic [12:0] abort_cause_in;
  logic        host_req, host_we;
  logic [7:0]  host_addr;
  logic [11:0] host_wdata;
  logic [31:0] host_rdata;
  logic        host_rvalid, irq_o;

  irq_event_bank dut (
    .clk(clk), .rst_n(rst_n), .src_in(src_in), .abort_cause_in(abort_cause_in),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int tests, fails;
  bit done;

  // bench model
  logic [11:0] m_lat, m_mask;
  logic [12:0] m_cause;
  logic [11:0] m_lvl;
  localparam logic [11:0] LVLB = 12'h014;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  function automatic int clr_of(input int b);
    case (b)
      0: return 'h44;  1: return 'h48;  3: return 'h4c;  5: return 'h50;
      6: return 'h54;  7: return 'h58;  8: return 'h5c;  9: return 'h60;
      10: return 'h64; 11: return 'h68;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_for(input logic [7:0] a);
    logic [11:0] raw;
    raw = m_lat | m_lvl;
    if (a == 8'h2c) return {20'd0, raw & m_mask};
    if (a == 8'h30) return {20'd0, m_mask};
    if (a == 8'h34) return {20'd0, raw};
    if (a == 8'h80) return {19'd0, m_cause};
    if (a == 8'h40) return {31'd0, |m_lat};
    for (int b = 0; b < 12; b++)
      if (clr_of(b) == int'(a)) return {31'd0, m_lat[b]};
    return 32'd0;
  endfunction

  function automatic void model_clear(input logic [7:0] a);
    if (a == 8'h40) begin m_lat = '0; m_cause = '0; end
    for (int b = 0; b < 12; b++)
      if (clr_of(b) == int'(a)) begin
        m_lat[b] = 1'b0;
        if (b == 6) m_cause = '0;
      end
  endfunction

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: compares read data when it appears
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL R11 unexpected read data actual=%0h expected=none", host_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(host_rdata, e, t);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = a;
    exp_q.push_back(exp_for(a)); tag_q.push_back(tag);
    model_clear(a);
    @(negedge clk);
    host_req = 0;
  endtask

  // clear read and source pulse on the same edge
  task automatic rd_evt(input logic [7:0] a, input logic [11:0] ev, input logic [12:0] cz, input string tag);
    @(negedge clk);
    host_req = 1; host_we = 0; host_addr = a;
    src_in = m_lvl | (ev & ~LVLB); abort_cause_in = cz;
    exp_q.push_back(exp_for(a)); tag_q.push_back(tag);
    model_clear(a);
    m_lat |= ev & ~LVLB;
    if (ev[6]) m_cause |= cz;
    @(negedge clk);
    host_req = 0; src_in = m_lvl; abort_cause_in = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [11:0] v);
    @(negedge clk);
    host_req = 1; host_we = 1; host_addr = a; host_wdata = v;
    if (a == 8'h30) m_mask = v;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic pulse(input logic [11:0] ev, input logic [12:0] cz);
    @(negedge clk);
    src_in = m_lvl | (ev & ~LVLB); abort_cause_in = cz;
    m_lat |= ev & ~LVLB;
    if (ev[6]) m_cause |= cz;
    @(negedge clk);
    src_in = m_lvl; abort_cause_in = '0;
  endtask

  task automatic set_lvl(input logic [11:0] l);
    @(negedge clk);
    m_lvl = l & LVLB;
    src_in = m_lvl;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 0;
    m_lat = '0; m_mask = '0; m_cause = '0; m_lvl = '0;
    rst_n = 0; src_in = '0; abort_cause_in = '0;
    host_req = 0; host_we = 0; host_addr = '0; host_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({31'd0, irq_o}, 32'd0, "R1 irq after reset");
    rd(8'h34, "R1 raw after reset");
    rd(8'h30, "R1 mask after reset");
    rd(8'h80, "R1 cause after reset");
    // R2 / R5 event with mask off
    pulse(12'h001, '0);
    chk({31'd0, irq_o}, 32'd0, "R5 irq masked off");
    rd(8'h34, "R2 raw underflow");
    rd(8'h2c, "R4 masked zero");
    wr(8'h30, 12'hfff);
    chk({31'd0, irq_o}, 32'd1, "R5 irq after mask");
    rd(8'h30, "R4 mask readback");
    pulse(12'h80a, '0);
    rd(8'h34, "R2 raw several");
    rd(8'h2c, "R4 masked full");
    // R6 single clears
    rd(8'h4c, "R6 clear tx overflow");
    rd(8'h34, "R6 raw after one clear");
    rd(8'h50, "R6 clear of unset bit");
    rd(8'h34, "R6 raw unchanged");
    // R3 / R7 levels and combined clear
    set_lvl(12'h004);
    rd(8'h34, "R3 rx full level");
    rd(8'h40, "R7 clear all");
    rd(8'h34, "R3 level survives clear");
    rd(8'h40, "R7 clear all when empty");
    set_lvl(12'h010);
    rd(8'h34, "R3 tx empty level");
    set_lvl(12'h000);
    rd(8'h34, "R3 level dropped");
    chk({31'd0, irq_o}, 32'd0, "R5 irq low when nothing set");
    // R8 / R9 abort causes
    pulse(12'h040, 13'h0009);
    pulse(12'h040, 13'h1000);
    rd(8'h80, "R8 cause accumulated");
    rd(8'h54, "R9 abort clear");
    rd(8'h80, "R9 cause cleared");
    rd(8'h34, "R9 raw after abort clear");
    pulse(12'h040, 13'h0020);
    rd(8'h40, "R7 clear all with abort");
    rd(8'h80, "R7 cause cleared by all");
    // R10 event wins
    pulse(12'h200, '0);
    rd_evt(8'h60, 12'h200, '0, "R10 stop clear race");
    rd(8'h34, "R10 stop kept");
    pulse(12'h040, 13'h0001);
    rd_evt(8'h54, 12'h040, 13'h0800, "R10 abort clear race");
    rd(8'h80, "R10 cause new only");
    rd(8'h40, "R7 clear before partial mask");
    // R5 partial mask
    wr(8'h30, 12'h001);
    pulse(12'h002, '0);
    chk({31'd0, irq_o}, 32'd0, "R5 unmasked source only");
    pulse(12'h001, '0);
    chk({31'd0, irq_o}, 32'd1, "R5 masked source fires");
    rd(8'h2c, "R4 partial masked view");
    // R11 unmapped and stray writes
    rd(8'h10, "R11 unmapped reads zero");
    wr(8'h34, 12'h000);
    wr(8'h48, 12'h000);
    rd(8'h34, "R11 writes changed nothing");
    rd(8'h30, "R11 mask kept");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL R11 missing read data actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule